// File: doc/BRIEF.md
# Zero-Turnaround Synchronous SRAM

A synthesizable model of a small synchronous static RAM, built so that a bus can go from read to write and back with no idle cycle between commands. Every input except the output-disable is captured on a rising clock edge. A write's data arrives a fixed number of edges after its command, the same number of edges a read takes to return data. A read command can therefore follow a write command directly, and a write can follow a read. Each word is made of byte lanes of nine bits, and each lane has its own active-low write strobe.

A static input selects between two latency modes. In registered (pipeline) mode a read returns after two edges and write data is taken two edges after the command. In flow mode both latencies are one edge. An on-chip two-bit burst counter lets a caller continue a read or a write at the next address of a four-word group, in linear or interleaved order. A hold input freezes the whole block for one edge at a time. A sleep input stops all activity, keeps the array contents, and turns off the data bus.

Top module: `zbus_sram`

## Requirements
- R1: A command is accepted only when `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0 with `adv`=0. If any enable is inactive, the edge is a deselect: nothing is stored and the bus is not driven for that slot.
- R2: With `adv`=0, `wr_n`=1 starts a read and `wr_n`=0 starts a write at `addr`.
- R3: Pipeline mode (`flow_mode`=0): call the command edge edge 1. Read data is on `d_out` with `d_oe`=1 after edge 2. Write data is sampled from `d_in` at edge 3. Alternating reads and writes need no idle cycle.
- R4: Flow mode (`flow_mode`=1): read data is on the bus after edge 1. Write data is sampled from `d_in` at edge 2.
- R5: `lane_we_n[i]`=0 stores bits [9i+8:9i] of the write data. A write with every strobe high stores nothing.
- R6: While `stall`=1 the edge changes no state. A read being driven stays on the bus unchanged. Write data that is due is taken one enabled edge later.
- R7: While `out_off`=1, `d_oe` is 0 at once, without a clock edge. Cycles that carry no read data leave `d_oe`=0.
- R8: With `adv`=1, the previous operation type continues at the next burst address. The upper address bits stay fixed. The two low bits step through base+n mod 4 when `interleave`=0, or base XOR n when `interleave`=1. The fifth access returns to the base. A continue that follows a deselect is again a deselect.
- R9: `sleep_req` sampled high on two consecutive edges puts the block to sleep from the second edge. While asleep, `d_oe`=0, all other inputs are ignored, and both the array and the pipeline keep their state. A read held before sleep is driven again on wake.
- R10: On the first edge at which `sleep_req` is sampled low, the block wakes. For the next `WAKE_CYCLES` (default 2) edges, write commands are turned into deselects. Reads are still served. Writes work again afterwards.
- R11: In pipeline mode, a read issued right after a write to the same address returns the new data in the enabled lanes and the old data in the others.
- R12: After reset, all stages hold deselects and `d_oe`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| flow_mode | input | 1 | Static: 1 flow mode, 0 pipeline mode |
| interleave | input | 1 | Static burst order: 1 interleaved, 0 linear |
| stall | input | 1 | 1 makes the block ignore the edge |
| sel_a_n | input | 1 | Chip enable, active low |
| sel_b | input | 1 | Chip enable, active high |
| sel_c_n | input | 1 | Chip enable, active low |
| wr_n | input | 1 | 1 read, 0 write |
| lane_we_n | input | LANES | Per-lane write strobes, active low |
| adv | input | 1 | 0 load a new command, 1 continue the burst |
| addr | input | ADDR_W | Word address |
| d_in | input | LANES*LANE_W | Write data |
| d_out | output | LANES*LANE_W | Read data |
| d_oe | output | 1 | Bus drive enable for d_out |
| out_off | input | 1 | Asynchronous forced bus release |
| sleep_req | input | 1 | Sleep request, active high |

## Verification
A full write sweep followed by a full read sweep over every address checks the basic latency in each of the four combinations of mode and burst order, and shows whether the address and the data are aligned. An interleaved stream of writes, same-address reads and unrelated reads, with every strobe pattern including all-off, shows whether the block serves traffic with no idle cycle and separates bypassed data from array data lane by lane. The burst runs start from each low-address offset and run past the wrap, which tells the linear order from the interleaved one. Directed sequences insert stalls into reads and into write-data windows, assert the async disable, switch each enable off in turn, and take the block through sleep and its wake window.

// File: rtl/zbus_sram_pkg.sv
package zbus_sram_pkg;

  // Kind of access held in a pipeline stage or in the burst tracker
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;

endpackage

// File: rtl/zbus_sram_cmd.sv
module zbus_sram_cmd
  import zbus_sram_pkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter int LANES      = 2,
  parameter int BURST_BITS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_en,
  input  logic              sel_a_n,
  input  logic              sel_b,
  input  logic              sel_c_n,
  input  logic              wr_n,
  input  logic [LANES-1:0]  lane_we_n,
  input  logic              adv,
  input  logic [ADDR_W-1:0] addr,
  input  logic              interleave,
  input  logic              block_wr,
  output op_e               cmd_op,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [LANES-1:0]  cmd_lanes
);

  localparam int HI_W = ADDR_W - BURST_BITS;

  op_e                   op_q, op_n;
  logic [ADDR_W-1:0]     base_q, base_n;
  logic [BURST_BITS-1:0] cnt_q, cnt_n;
  logic [BURST_BITS-1:0] low_bits;
  logic                  selected;

  assign selected = !sel_a_n && sel_b && !sel_c_n;

  // Decode: load a new command or advance the running burst
  always_comb begin
    op_n   = op_q;
    base_n = base_q;
    cnt_n  = cnt_q;
    if (!adv) begin
      base_n = addr;
      cnt_n  = '0;
      if (selected) op_n = wr_n ? OP_READ : OP_WRITE;
      else          op_n = OP_IDLE;
    end else if (op_q != OP_IDLE) begin
      cnt_n = cnt_q + BURST_BITS'(1);
    end
    if (block_wr && (op_n == OP_WRITE)) op_n = OP_IDLE;
  end

  // Burst address order within the aligned group
  always_comb begin
    if (interleave) low_bits = base_n[BURST_BITS-1:0] ^ cnt_n;
    else            low_bits = base_n[BURST_BITS-1:0] + cnt_n;
  end

  assign cmd_op    = op_n;
  assign cmd_addr  = {base_n[ADDR_W-1:BURST_BITS], low_bits};
  assign cmd_lanes = (op_n == OP_WRITE) ? ~lane_we_n : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= OP_IDLE;
      base_q <= '0;
      cnt_q  <= '0;
    end else if (step_en) begin
      op_q   <= op_n;
      base_q <= base_n;
      cnt_q  <= cnt_n;
    end
  end

  // R8: continuing after a deselect stays deselected
  a_r8_idle_continue: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && adv && (op_q == OP_IDLE)) |=> (op_q == OP_IDLE));

  logic [HI_W-1:0] unused_hi;
  assign unused_hi = base_q[ADDR_W-1:BURST_BITS];

endmodule

// File: rtl/zbus_sram_sleep.sv
module zbus_sram_sleep #(
  parameter int WAKE_CYCLES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_req,
  output logic asleep,
  output logic recovering
);

  localparam int CW = $clog2(WAKE_CYCLES + 1);

  logic          seen_q, seen_n;
  logic          asleep_q, asleep_n;
  logic [CW-1:0] wake_q, wake_n;

  always_comb begin
    seen_n   = sleep_req;
    asleep_n = sleep_req && (seen_q || asleep_q);
    if (asleep_q && !sleep_req) wake_n = CW'(WAKE_CYCLES);
    else if (wake_q != '0)      wake_n = wake_q - CW'(1);
    else                        wake_n = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q   <= 1'b0;
      asleep_q <= 1'b0;
      wake_q   <= '0;
    end else begin
      seen_q   <= seen_n;
      asleep_q <= asleep_n;
      wake_q   <= wake_n;
    end
  end

  assign asleep     = asleep_q;
  assign recovering = (wake_q != '0);

  // R9: second consecutive high sample enters sleep
  a_r9_enter_sleep: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_req && seen_q) |=> asleep);

  // R10: leaving sleep opens the recovery window
  a_r10_wake_window: assert property (@(posedge clk) disable iff (!rst_n)
    (asleep_q && !sleep_req) |=> (recovering && !asleep));

endmodule

// File: rtl/zbus_sram_array.sv
module zbus_sram_array #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    we,
  input  logic [LANES-1:0]        wr_lanes,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [LANES*LANE_W-1:0] wr_data,
  input  logic [ADDR_W-1:0]       rd_addr,
  output logic [LANES*LANE_W-1:0] rd_data
);

  localparam int DEPTH  = 1 << ADDR_W;
  localparam int DATA_W = LANES * LANE_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      for (int l = 0; l < LANES; l++) begin
        if (wr_lanes[l]) mem[wr_addr][l*LANE_W +: LANE_W] <= wr_data[l*LANE_W +: LANE_W];
      end
    end
  end

  assign rd_data = mem[rd_addr];

endmodule

// File: rtl/zbus_sram.sv
module zbus_sram
  import zbus_sram_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int LANES       = 2,
  parameter int LANE_W      = 9,
  parameter int BURST_BITS  = 2,
  parameter int WAKE_CYCLES = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    flow_mode,
  input  logic                    interleave,
  input  logic                    stall,
  input  logic                    sel_a_n,
  input  logic                    sel_b,
  input  logic                    sel_c_n,
  input  logic                    wr_n,
  input  logic [LANES-1:0]        lane_we_n,
  input  logic                    adv,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] d_in,
  output logic [LANES*LANE_W-1:0] d_out,
  output logic                    d_oe,
  input  logic                    out_off,
  input  logic                    sleep_req
);

  localparam int DATA_W = LANES * LANE_W;

  // Reset: asserted asynchronously, released through two flops
  logic [1:0] rst_pipe_q;
  logic       rst_n_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_i = rst_pipe_q[1];

  logic asleep, recovering, step_en;

  zbus_sram_sleep #(.WAKE_CYCLES(WAKE_CYCLES)) u_sleep (
    .clk        (clk),
    .rst_n      (rst_n_i),
    .sleep_req  (sleep_req),
    .asleep     (asleep),
    .recovering (recovering)
  );

  assign step_en = !stall && !asleep;

  op_e               cmd_op;
  logic [ADDR_W-1:0] cmd_addr;
  logic [LANES-1:0]  cmd_lanes;

  zbus_sram_cmd #(.ADDR_W(ADDR_W), .LANES(LANES), .BURST_BITS(BURST_BITS)) u_cmd (
    .clk        (clk),
    .rst_n      (rst_n_i),
    .step_en    (step_en),
    .sel_a_n    (sel_a_n),
    .sel_b      (sel_b),
    .sel_c_n    (sel_c_n),
    .wr_n       (wr_n),
    .lane_we_n  (lane_we_n),
    .adv        (adv),
    .addr       (addr),
    .interleave (interleave),
    .block_wr   (recovering),
    .cmd_op     (cmd_op),
    .cmd_addr   (cmd_addr),
    .cmd_lanes  (cmd_lanes)
  );

  // Stage 1 holds the command just captured, stage 2 the one before it
  op_e               s1_op_q, s1_op_n, s2_op_q, s2_op_n;
  logic [ADDR_W-1:0] s1_addr_q, s1_addr_n, s2_addr_q, s2_addr_n;
  logic [LANES-1:0]  s1_lanes_q, s1_lanes_n, s2_lanes_q, s2_lanes_n;
  logic [DATA_W-1:0] out_q, out_n;
  logic              out_vld_q, out_vld_n;

  // Array write port: stage 1 in flow mode, stage 2 in pipeline mode
  logic              wr_we;
  logic [LANES-1:0]  wr_lanes;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] rd_data;

  always_comb begin
    if (flow_mode) begin
      wr_we    = step_en && (s1_op_q == OP_WRITE);
      wr_lanes = s1_lanes_q;
      wr_addr  = s1_addr_q;
    end else begin
      wr_we    = step_en && (s2_op_q == OP_WRITE);
      wr_lanes = s2_lanes_q;
      wr_addr  = s2_addr_q;
    end
  end

  zbus_sram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk      (clk),
    .we       (wr_we),
    .wr_lanes (wr_lanes),
    .wr_addr  (wr_addr),
    .wr_data  (d_in),
    .rd_addr  (s1_addr_q),
    .rd_data  (rd_data)
  );

  // Pipeline bypass: a write retiring on this edge feeds the read behind it
  logic              hit;
  logic [DATA_W-1:0] merged;

  assign hit = (s2_op_q == OP_WRITE) && (s2_addr_q == s1_addr_q);

  for (genvar g = 0; g < LANES; g++) begin : g_merge
    assign merged[g*LANE_W +: LANE_W] = (hit && s2_lanes_q[g]) ?
                                        d_in[g*LANE_W +: LANE_W] :
                                        rd_data[g*LANE_W +: LANE_W];
  end

  always_comb begin
    s1_op_n    = s1_op_q;
    s1_addr_n  = s1_addr_q;
    s1_lanes_n = s1_lanes_q;
    s2_op_n    = s2_op_q;
    s2_addr_n  = s2_addr_q;
    s2_lanes_n = s2_lanes_q;
    out_n      = out_q;
    out_vld_n  = out_vld_q;
    if (step_en) begin
      s1_op_n    = cmd_op;
      s1_addr_n  = cmd_addr;
      s1_lanes_n = cmd_lanes;
      s2_op_n    = s1_op_q;
      s2_addr_n  = s1_addr_q;
      s2_lanes_n = s1_lanes_q;
      out_vld_n  = (s1_op_q == OP_READ);
      if (s1_op_q == OP_READ) out_n = merged;
    end
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      s1_op_q    <= OP_IDLE;
      s1_addr_q  <= '0;
      s1_lanes_q <= '0;
      s2_op_q    <= OP_IDLE;
      s2_addr_q  <= '0;
      s2_lanes_q <= '0;
      out_q      <= '0;
      out_vld_q  <= 1'b0;
    end else begin
      s1_op_q    <= s1_op_n;
      s1_addr_q  <= s1_addr_n;
      s1_lanes_q <= s1_lanes_n;
      s2_op_q    <= s2_op_n;
      s2_addr_q  <= s2_addr_n;
      s2_lanes_q <= s2_lanes_n;
      out_q      <= out_n;
      out_vld_q  <= out_vld_n;
    end
  end

  logic drive;
  assign drive = flow_mode ? (s1_op_q == OP_READ) : out_vld_q;
  assign d_out = flow_mode ? rd_data : out_q;
  assign d_oe  = drive && !out_off && !asleep;

  // R1: an inactive enable on a load edge leaves a deselect in stage 1
  a_r1_deselect: assert property (@(posedge clk) disable iff (!rst_n_i)
    (step_en && !adv && (sel_a_n || !sel_b || sel_c_n)) |=> (s1_op_q == OP_IDLE));

  // R6: a stalled edge leaves the read data untouched
  a_r6_stall_holds: assert property (@(posedge clk) disable iff (!rst_n_i)
    stall |=> $stable(d_out));

  // R7: the async disable always wins
  a_r7_out_off: assert property (@(posedge clk) disable iff (!rst_n_i)
    out_off |-> !d_oe);

  // R9: no drive while asleep
  a_r9_sleep_quiet: assert property (@(posedge clk) disable iff (!rst_n_i)
    asleep |-> !d_oe);

  // R10: no write enters the pipeline during recovery
  a_r10_no_write: assert property (@(posedge clk) disable iff (!rst_n_i)
    (step_en && recovering) |=> (s1_op_q != OP_WRITE));

endmodule

// File: tb/zbus_sram_bench.sv
module zbus_sram_bench;

  localparam int AW = 6;
  localparam int DW = 18;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          flow_mode, interleave, stall;
  logic          sel_a_n, sel_b, sel_c_n, wr_n, adv;
  logic [1:0]    lane_we_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] d_in, d_out;
  logic          d_oe, out_off, sleep_req;

  always #4 clk = ~clk;

  zbus_sram u_zbus_sram (
    .clk(clk), .rst_n(rst_n), .flow_mode(flow_mode), .interleave(interleave),
    .stall(stall), .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
    .wr_n(wr_n), .lane_we_n(lane_we_n), .adv(adv), .addr(addr), .d_in(d_in),
    .d_out(d_out), .d_oe(d_oe), .out_off(out_off), .sleep_req(sleep_req)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  int seed_base = 0;

  logic [DW-1:0] ref_mem [64];

  // Command script: load flag, write flag, select code, lane mask, address
  logic          c_ld  [256];
  logic          c_wr  [256];
  logic [1:0]    c_sel [256];
  logic [1:0]    c_ln  [256];
  logic [AW-1:0] c_ad  [256];
  int            e_op  [256];
  logic [DW-1:0] e_dat [256];
  logic [DW-1:0] wdat  [256];

  function automatic logic [DW-1:0] pat(int i);
    return DW'((i * 4663 + 77) ^ (i << 7));
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Drive one command at a falling edge, return at the next falling edge
  task automatic drive1(input logic ld, input logic wr, input logic [1:0] sel,
                        input logic [1:0] lanes, input logic [AW-1:0] a,
                        input logic [DW-1:0] din, input logic st);
    adv       = !ld;
    wr_n      = !wr;
    sel_a_n   = (sel == 2'd1);
    sel_b     = (sel != 2'd2);
    sel_c_n   = (sel == 2'd3);
    lane_we_n = ~lanes;
    addr      = a;
    d_in      = din;
    stall     = st;
    @(negedge clk);
  endtask

  task automatic desel(input logic [DW-1:0] din);
    drive1(1'b1, 1'b0, 2'd1, 2'b00, '0, din, 1'b0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    stall = 1'b0; out_off = 1'b0; sleep_req = 1'b0;
    adv = 1'b0; wr_n = 1'b1; sel_a_n = 1'b1; sel_b = 1'b0; sel_c_n = 1'b1;
    lane_we_n = '1; addr = '0; d_in = '0;
    repeat (2) @(negedge clk);
    chk(d_oe === 1'b0, "R12 in reset", 32'(d_oe), 0);
    rst_n = 1'b1;
    repeat (3) desel('0);
    chk(d_oe === 1'b0, "R12 after reset", 32'(d_oe), 0);
  endtask

  // Run a scripted stream; the bench model resolves bursts and data in order
  task automatic run_seq(input int n, input string tag);
    int            op, lat;
    logic [AW-1:0] base, ea;
    logic [1:0]    cnt;
    logic [DW-1:0] din;
    op = 0; base = '0; cnt = '0;
    for (int i = 0; i < n; i++) begin
      if (c_ld[i]) begin
        base = c_ad[i]; cnt = '0;
        op = (c_sel[i] == 2'd0) ? (c_wr[i] ? 2 : 1) : 0;
      end else if (op != 0) begin
        cnt = cnt + 2'd1;
      end
      ea = {base[AW-1:2], interleave ? (base[1:0] ^ cnt) : (base[1:0] + cnt)};
      e_op[i] = op;
      wdat[i] = pat(seed_base + i);
      if (op == 2) begin
        for (int l = 0; l < 2; l++)
          if (c_ln[i][l]) ref_mem[ea][l*9 +: 9] = wdat[i][l*9 +: 9];
      end
      e_dat[i] = ref_mem[ea];
    end
    seed_base += n;
    lat = flow_mode ? 1 : 2;
    for (int s = 0; s < n + lat; s++) begin
      int r;
      din = DW'(18'h15A5A ^ s);
      if (s >= lat && e_op[s-lat] == 2) din = wdat[s-lat];
      if (s < n) drive1(c_ld[s], c_wr[s], c_sel[s], c_ln[s], c_ad[s], din, 1'b0);
      else       desel(din);
      r = s - (lat - 1);
      if (r >= 0 && r < n) begin
        if (e_op[r] == 1)
          chk(d_oe === 1'b1 && d_out === e_dat[r], tag, 32'({d_oe, d_out}), 32'({1'b1, e_dat[r]}));
        else
          chk(d_oe === 1'b0, tag, 32'(d_oe), 0);
      end
    end
  endtask

  task automatic put(input int i, input logic ld, input logic wr, input logic [1:0] sel,
                     input logic [1:0] ln, input logic [AW-1:0] a);
    c_ld[i] = ld; c_wr[i] = wr; c_sel[i] = sel; c_ln[i] = ln; c_ad[i] = a;
  endtask

  task automatic read_hold(input logic [AW-1:0] a);
    drive1(1'b1, 1'b0, 2'd0, 2'b00, a, '0, 1'b0);
    if (!flow_mode) desel('0);
  endtask

  initial begin
    flow_mode = 1'b0; interleave = 1'b0;
    for (int cfg = 0; cfg < 4; cfg++) begin
      int n;
      flow_mode  = cfg[0];
      interleave = cfg[1];
      do_reset();

      // Full write sweep then full read sweep (R2 / R3 / R4)
      for (int a = 0; a < 64; a++) put(a, 1'b1, 1'b1, 2'd0, 2'b11, AW'(a));
      for (int a = 0; a < 64; a++) put(64 + a, 1'b1, 1'b0, 2'd0, 2'b00, AW'(a));
      run_seq(128, interleave ? "R2 sweep" : (flow_mode ? "R4 sweep" : "R3 sweep"));

      // Mixed write / hit read / other read with all strobe patterns (R5 / R11)
      for (int i = 0; i < 96; i++) begin
        int j;
        j = i / 3;
        case (i % 3)
          0:       put(i, 1'b1, 1'b1, 2'd0, 2'(j % 4), AW'((j * 7) % 16));
          1:       put(i, 1'b1, 1'b0, 2'd0, 2'b00, AW'((j * 7) % 16));
          default: put(i, 1'b1, 1'b0, 2'd0, 2'b00, AW'((j * 5 + 3) % 16));
        endcase
      end
      run_seq(96, flow_mode ? "R5 mixed" : "R11 mixed");

      // Bursts from each low offset, reads run past the wrap (R8)
      n = 0;
      for (int b = 0; b < 4; b++) begin
        logic [AW-1:0] base;
        base = {4'(8 + b), 2'(b)};
        put(n, 1'b1, 1'b1, 2'd0, 2'b11, base); n++;
        put(n, 1'b0, 1'b1, 2'd0, 2'b11, '0);   n++;
        put(n, 1'b0, 1'b1, 2'd0, 2'b01, '0);   n++;
        put(n, 1'b0, 1'b1, 2'd0, 2'b10, '0);   n++;
        put(n, 1'b1, 1'b0, 2'd0, 2'b00, base); n++;
        for (int k = 0; k < 4; k++) begin put(n, 1'b0, 1'b0, 2'd0, 2'b00, '0); n++; end
      end
      put(n, 1'b1, 1'b0, 2'd1, 2'b00, 6'd3); n++;
      put(n, 1'b0, 1'b0, 2'd0, 2'b00, '0);   n++;
      put(n, 1'b0, 1'b1, 2'd0, 2'b11, '0);   n++;
      run_seq(n, "R8 burst");

      // Each enable off in turn (R1)
      n = 0;
      for (int sc = 1; sc < 4; sc++) begin
        put(n, 1'b1, 1'b1, 2'(sc), 2'b11, AW'(48 + sc)); n++;
        put(n, 1'b1, 1'b0, 2'd0,   2'b00, AW'(48 + sc)); n++;
        put(n, 1'b1, 1'b0, 2'(sc), 2'b00, AW'(48 + sc)); n++;
      end
      run_seq(n, "R1 enables");

      // Stall across a driven read (R6)
      read_hold(6'd60);
      chk(d_oe === 1'b1 && d_out === ref_mem[60], "R6 before stall", 32'(d_out), 32'(ref_mem[60]));
      for (int k = 0; k < 2; k++) begin
        drive1(1'b1, 1'b1, 2'd0, 2'b11, 6'd9, 18'h3FFFF, 1'b1);
        chk(d_oe === 1'b1 && d_out === ref_mem[60], "R6 stalled read", 32'({d_oe, d_out}), 32'({1'b1, ref_mem[60]}));
      end
      desel('0);
      chk(d_oe === 1'b0, "R6 after stall", 32'(d_oe), 0);

      // Stall inside a write data window (R6)
      begin
        logic [DW-1:0] v;
        v = DW'(18'h2F0F3 ^ cfg);
        drive1(1'b1, 1'b1, 2'd0, 2'b11, 6'd61, '0, 1'b0);
        drive1(1'b1, 1'b0, 2'd1, 2'b00, '0, 18'h0DEAD, 1'b1);
        chk(d_oe === 1'b0, "R6 stalled write", 32'(d_oe), 0);
        for (int j = 1; j <= (flow_mode ? 1 : 2); j++)
          desel((j == (flow_mode ? 1 : 2)) ? v : 18'h0BEEF);
        ref_mem[61] = v;
        read_hold(6'd61);
        chk(d_oe === 1'b1 && d_out === v, "R6 write after stall", 32'(d_out), 32'(v));
        desel('0);
      end

      // Asynchronous disable (R7)
      read_hold(6'd60);
      out_off = 1'b1; #1;
      chk(d_oe === 1'b0, "R7 out_off", 32'(d_oe), 0);
      out_off = 1'b0; #1;
      chk(d_oe === 1'b1, "R7 out_off released", 32'(d_oe), 1);
      desel('0);

      // Sleep entry, retention and wake window (R9 / R10), pipeline mode
      if (!flow_mode) begin
        logic [DW-1:0] v2;
        read_hold(6'd60);
        sleep_req = 1'b1;
        drive1(1'b1, 1'b0, 2'd1, 2'b00, '0, '0, 1'b1);
        chk(d_oe === 1'b1, "R9 one edge not asleep", 32'(d_oe), 1);
        drive1(1'b1, 1'b0, 2'd1, 2'b00, '0, '0, 1'b1);
        chk(d_oe === 1'b0, "R9 asleep", 32'(d_oe), 0);
        for (int k = 0; k < 2; k++) begin
          drive1(1'b1, 1'b1, 2'd0, 2'b11, 6'd60, 18'h12345, 1'b0);
          chk(d_oe === 1'b0, "R9 inputs ignored", 32'(d_oe), 0);
        end
        sleep_req = 1'b0;
        drive1(1'b1, 1'b1, 2'd0, 2'b11, 6'd60, 18'h12345, 1'b0);
        chk(d_oe === 1'b1 && d_out === ref_mem[60], "R9 state kept", 32'({d_oe, d_out}), 32'({1'b1, ref_mem[60]}));
        drive1(1'b1, 1'b1, 2'd0, 2'b11, 6'd60, 18'h12345, 1'b0);
        drive1(1'b1, 1'b1, 2'd0, 2'b11, 6'd60, 18'h23456, 1'b0);
        desel(18'h34567);
        desel(18'h01234);
        read_hold(6'd60);
        chk(d_oe === 1'b1 && d_out === ref_mem[60], "R10 writes blocked", 32'(d_out), 32'(ref_mem[60]));
        v2 = DW'(18'h1C3C3 ^ cfg);
        drive1(1'b1, 1'b1, 2'd0, 2'b11, 6'd60, '0, 1'b0);
        desel('0);
        desel(v2);
        ref_mem[60] = v2;
        read_hold(6'd60);
        chk(d_oe === 1'b1 && d_out === v2, "R10 writes resume", 32'(d_out), 32'(v2));
        desel('0);
      end
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule